// File: doc/BRIEF.md
# Segmented MMIO Window Partition Decoder

This block resolves which partitionable endpoint (PE) owns a 64-bit memory-mapped I/O address. It keeps a small table of address windows. Each window is a power-of-two sized range, described by a base and a contiguous high-order mask. A window either maps its whole range to one PE, or divides its range into equal segments that map onto consecutive PE numbers. The segment is picked by the address bits just below the mask boundary, not by comparing against base and limit registers.

Software fills the table through a one-cycle write port. Each write is checked before it is stored. A write that breaks the alignment, size or base-PE rules leaves the entry as it was and raises a sticky error flag. Lookups enter through a valid/ready request channel. One cycle later the registered response gives the hit flag, the PE number and the index of the winning window. When windows overlap, the lowest-numbered window wins.

Top module: `pew_decoder`

## Requirements
- R1: After reset every window is disabled, `err` is 0, `rsp_valid` is 0 and `req_ready` is 1, so the first lookup misses.
- R2: An entry hits only when it is enabled and (address AND mask) equals its base. A write with `wr_enable`=0 is always accepted and only disables the entry.
- R3: Mode 0 (full split) divides the window into 2^PE_W segments. The PE number is the PE_W address bits directly below the lowest set mask bit. `wr_pe` is ignored in this mode.
- R4: Mode 1 (single PE) maps every address in the window to the programmed `wr_pe` value.
- R5: Modes 2, 3 and 4 divide the window into 8, 64 and 128 segments. The PE number is `wr_pe` + segment, where the segment is the 3, 6 or 7 address bits directly below the lowest set mask bit.
- R6: When several enabled entries hit, the lowest-numbered entry supplies `rsp_pe`, and its index appears on `rsp_win`.
- R7: On a miss, `rsp_hit`=0, `rsp_pe`=0 and `rsp_win`=0.
- R8: An enabling write is rejected and leaves the entry unchanged if any of these holds:
  - the mask's zero bits are not contiguous from bit 0;
  - the base has a 1 where the mask is 0;
  - a split window is smaller than its segment count in bytes;
  - a single-PE window is smaller than 32 MB (2^25 bytes);
  - in modes 2 to 4, `wr_pe` is not a multiple of the segment count;
  - the mode is 5, 6 or 7.
- R9: `err` is set by a rejected write and stays at 1 until `err_clr`. If a rejection and `err_clr` fall in the same cycle, `err` stays at 1.
- R10: A request accepted at a clock edge gives `rsp_valid` after that same edge. The response holds steady while `rsp_ready` is 0. `req_ready` is 0 exactly while a held response is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 4 | Entry being written |
| wr_enable | input | 1 | 1 enables the entry with the new fields, 0 disables it |
| wr_mode | input | 3 | Decode mode (0 full split, 1 single, 2/3/4 split into 8/64/128) |
| wr_base | input | 64 | Window base address |
| wr_mask | input | 64 | Window mask (contiguous high ones) |
| wr_pe | input | 8 | PE number (single mode) or base PE (modes 2 to 4) |
| err_clr | input | 1 | Clears the sticky error flag |
| err | output | 1 | Sticky rejected-write flag |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_addr | input | 64 | Address to decode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_hit | output | 1 | Some enabled window matched |
| rsp_pe | output | 8 | Owning PE number |
| rsp_win | output | 4 | Index of the winning window |

## Verification
The hardest case to reach from the ports is a rejected write aimed at an entry that is already live. It only shows up if later lookups in that window still give the old decode. The bench therefore programs entry 0 first, then sends it a write with a misaligned base. After that it decodes an address inside the old window and expects the old segment PE. Priority is reached in a similar way: a second window is laid over entry 0, and entry 0 is then disabled so the same address moves to the other window.

// File: rtl/pew_pkg.sv
package pew_pkg;

  typedef enum logic [2:0] {
    MODE_SPLIT_ALL = 3'd0,
    MODE_SINGLE    = 3'd1,
    MODE_SPLIT_8   = 3'd2,
    MODE_SPLIT_64  = 3'd3,
    MODE_SPLIT_128 = 3'd4
  } mode_e;

  localparam int SPLIT_8_BITS   = 3;
  localparam int SPLIT_64_BITS  = 6;
  localparam int SPLIT_128_BITS = 7;

  // Number of segment-select bits a mode uses; -1 marks an illegal mode.
  function automatic int seg_bits(input logic [2:0] mode, input int pe_w);
    case (mode)
      3'd0:    seg_bits = pe_w;
      3'd1:    seg_bits = 0;
      3'd2:    seg_bits = SPLIT_8_BITS;
      3'd3:    seg_bits = SPLIT_64_BITS;
      3'd4:    seg_bits = SPLIT_128_BITS;
      default: seg_bits = -1;
    endcase
  endfunction

endpackage

// File: rtl/pew_entry_check.sv
module pew_entry_check #(
  parameter int ADDR_W          = 64,
  parameter int PE_W            = 8,
  parameter int SHIFT_W         = 7,
  parameter int SINGLE_MIN_LOG2 = 25
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  mask,
  input  logic [2:0]         mode,
  input  logic [PE_W-1:0]    pe,
  output logic               ok,
  output logic [SHIFT_W-1:0] shift,
  output logic [PE_W-1:0]    seg_mask,
  output logic [PE_W-1:0]    pe_base
);
  import pew_pkg::*;

  logic [ADDR_W-1:0]  low;
  logic               contig, aligned, legal, big_enough, pe_ok;
  logic [SHIFT_W-1:0] win_log2, sbits;
  int                 sb;

  always_comb begin
    low      = ~mask;
    contig   = ((low & (low + 1'b1)) == '0);
    aligned  = ((base & low) == '0);
    win_log2 = SHIFT_W'($countones(low));
    sb       = seg_bits(mode, PE_W);
    legal    = (sb >= 0) && (sb <= PE_W);
    sbits    = legal ? SHIFT_W'(sb) : '0;
    seg_mask = PE_W'((32'd1 << sbits) - 32'd1);
    shift    = win_log2 - sbits;

    if (mode == MODE_SINGLE)
      big_enough = (win_log2 >= SHIFT_W'(SINGLE_MIN_LOG2));
    else
      big_enough = (win_log2 >= sbits);

    // Extended split modes need the base PE to be a segment-count multiple.
    pe_ok   = ((pe & seg_mask) == '0) || (mode == MODE_SPLIT_ALL);
    pe_base = (mode == MODE_SPLIT_ALL) ? '0 : pe;
    ok      = contig && aligned && legal && big_enough && pe_ok;
  end

endmodule

// File: rtl/pew_window_table.sv
module pew_window_table #(
  parameter int NUM_WIN = 16,
  parameter int ADDR_W  = 64,
  parameter int PE_W    = 8,
  parameter int SHIFT_W = 7,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_enable,
  input  logic               wr_ok,
  input  logic [ADDR_W-1:0]  wr_base,
  input  logic [ADDR_W-1:0]  wr_mask,
  input  logic [SHIFT_W-1:0] wr_shift,
  input  logic [PE_W-1:0]    wr_segmask,
  input  logic [PE_W-1:0]    wr_pebase,
  input  logic               err_clr,
  output logic               err,
  output logic [NUM_WIN-1:0] ent_en,
  output logic [ADDR_W-1:0]  ent_base    [NUM_WIN],
  output logic [ADDR_W-1:0]  ent_mask    [NUM_WIN],
  output logic [SHIFT_W-1:0] ent_shift   [NUM_WIN],
  output logic [PE_W-1:0]    ent_segmask [NUM_WIN],
  output logic [PE_W-1:0]    ent_pebase  [NUM_WIN]
);

  logic accept, reject;

  assign accept = wr_en && wr_enable && wr_ok;
  assign reject = wr_en && wr_enable && !wr_ok;

  // Enables carry a reset; the data fields only matter once enabled.
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_en <= '0;
    end else if (wr_en) begin
      if (!wr_enable)  ent_en[wr_idx] <= 1'b0;
      else if (wr_ok)  ent_en[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      ent_base[wr_idx]    <= wr_base;
      ent_mask[wr_idx]    <= wr_mask;
      ent_shift[wr_idx]   <= wr_shift;
      ent_segmask[wr_idx] <= wr_segmask;
      ent_pebase[wr_idx]  <= wr_pebase;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          err <= 1'b0;
    else if (reject)  err <= 1'b1;
    else if (err_clr) err <= 1'b0;
  end

endmodule

// File: rtl/pew_match.sv
module pew_match #(
  parameter int ADDR_W  = 64,
  parameter int PE_W    = 8,
  parameter int SHIFT_W = 7
) (
  input  logic               en,
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  mask,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [PE_W-1:0]    segmask,
  input  logic [PE_W-1:0]    pebase,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [PE_W-1:0]    pe
);

  logic [PE_W-1:0] seg;

  always_comb begin
    hit = en && ((addr & mask) == base);
    seg = PE_W'(addr >> shift) & segmask;
    pe  = pebase | seg;
  end

endmodule

// File: rtl/pew_decoder.sv
module pew_decoder #(
  parameter int NUM_WIN         = 16,
  parameter int ADDR_W          = 64,
  parameter int PE_W            = 8,
  parameter int SINGLE_MIN_LOG2 = 25,
  localparam int IDX_W          = $clog2(NUM_WIN),
  localparam int SHIFT_W        = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_enable,
  input  logic [2:0]        wr_mode,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_mask,
  input  logic [PE_W-1:0]   wr_pe,
  input  logic              err_clr,
  output logic              err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PE_W-1:0]   rsp_pe,
  output logic [IDX_W-1:0]  rsp_win
);

  logic               chk_ok;
  logic [SHIFT_W-1:0] chk_shift;
  logic [PE_W-1:0]    chk_segmask, chk_pebase;

  pew_entry_check #(
    .ADDR_W(ADDR_W), .PE_W(PE_W), .SHIFT_W(SHIFT_W),
    .SINGLE_MIN_LOG2(SINGLE_MIN_LOG2)
  ) u_check (
    .base(wr_base), .mask(wr_mask), .mode(wr_mode), .pe(wr_pe),
    .ok(chk_ok), .shift(chk_shift), .seg_mask(chk_segmask),
    .pe_base(chk_pebase)
  );

  logic [NUM_WIN-1:0] ent_en;
  logic [ADDR_W-1:0]  ent_base    [NUM_WIN];
  logic [ADDR_W-1:0]  ent_mask    [NUM_WIN];
  logic [SHIFT_W-1:0] ent_shift   [NUM_WIN];
  logic [PE_W-1:0]    ent_segmask [NUM_WIN];
  logic [PE_W-1:0]    ent_pebase  [NUM_WIN];

  pew_window_table #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .PE_W(PE_W), .SHIFT_W(SHIFT_W)
  ) u_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_enable(wr_enable), .wr_ok(chk_ok), .wr_base(wr_base),
    .wr_mask(wr_mask), .wr_shift(chk_shift), .wr_segmask(chk_segmask),
    .wr_pebase(chk_pebase), .err_clr(err_clr), .err(err),
    .ent_en(ent_en), .ent_base(ent_base), .ent_mask(ent_mask),
    .ent_shift(ent_shift), .ent_segmask(ent_segmask),
    .ent_pebase(ent_pebase)
  );

  logic [NUM_WIN-1:0] hit_v;
  logic [PE_W-1:0]    pe_v [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    pew_match #(
      .ADDR_W(ADDR_W), .PE_W(PE_W), .SHIFT_W(SHIFT_W)
    ) u_match (
      .en(ent_en[g]), .base(ent_base[g]), .mask(ent_mask[g]),
      .shift(ent_shift[g]), .segmask(ent_segmask[g]),
      .pebase(ent_pebase[g]), .addr(req_addr),
      .hit(hit_v[g]), .pe(pe_v[g])
    );
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  logic             sel_hit;
  logic [PE_W-1:0]  sel_pe;
  logic [IDX_W-1:0] sel_idx;

  always_comb begin
    sel_hit = 1'b0;
    sel_pe  = '0;
    sel_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        sel_hit = 1'b1;
        sel_pe  = pe_v[i];
        sel_idx = IDX_W'(i);
      end
    end
  end

  logic fire;
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst)            rsp_valid <= 1'b0;
    else if (fire)      rsp_valid <= 1'b1;
    else if (rsp_ready) rsp_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_hit <= 1'b0;
      rsp_pe  <= '0;
      rsp_win <= '0;
    end else if (fire) begin
      rsp_hit <= sel_hit;
      rsp_pe  <= sel_pe;
      rsp_win <= sel_idx;
    end
  end

endmodule

// File: rtl/pew_decoder_chk.sv
module pew_decoder_chk #(
  parameter int PE_W  = 8,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             err_clr,
  input logic             err,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [PE_W-1:0]  rsp_pe,
  input logic [IDX_W-1:0] rsp_win
);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) &&
                                $stable(rsp_pe) && $stable(rsp_win));

  // R10
  req_block_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R10
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> rsp_pe == '0 && rsp_win == '0);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err && !err_clr |=> err);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !err && !wr_en |=> !err);

endmodule

bind pew_decoder pew_decoder_chk #(.PE_W(PE_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .err_clr(err_clr), .err(err),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_pe(rsp_pe),
  .rsp_win(rsp_win)
);

// File: tb/tb_pew_decoder.sv
module tb_pew_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_enable = 1'b0, err_clr = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [2:0]  wr_mode = '0;
  logic [63:0] wr_base = '0, wr_mask = '0, req_addr = '0;
  logic [7:0]  wr_pe = '0;
  logic        req_valid = 1'b0, rsp_ready = 1'b1;
  logic        err, req_ready, rsp_valid, rsp_hit;
  logic [7:0]  rsp_pe;
  logic [3:0]  rsp_win;

  int errors = 0;
  int checks = 0;
  logic [12:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pew_decoder dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_enable(wr_enable), .wr_mode(wr_mode), .wr_base(wr_base),
    .wr_mask(wr_mask), .wr_pe(wr_pe), .err_clr(err_clr), .err(err),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_pe(rsp_pe), .rsp_win(rsp_win)
  );

  function automatic logic [63:0] mk(input int k);
    return ~((64'd1 << k) - 64'd1);
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: a response is consumed when valid and ready.
  always @(negedge clk) begin
    if (!rst && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected response", {51'd0, rsp_hit, rsp_pe, rsp_win}, 64'd0);
      end else begin
        logic [12:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rsp_hit, rsp_pe, rsp_win} == e, t,
              {51'd0, rsp_hit, rsp_pe, rsp_win}, {51'd0, e});
      end
    end
  end

  task automatic wr(input logic [3:0] idx, input logic [63:0] base,
                    input logic [63:0] mask, input logic [2:0] mode,
                    input logic en, input logic [7:0] pe, input logic clr);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_idx = idx; wr_base = base; wr_mask = mask;
    wr_mode = mode; wr_enable = en; wr_pe = pe; err_clr = clr;
    @(posedge clk); #1;
    wr_en = 1'b0; err_clr = 1'b0;
  endtask

  task automatic clear_err();
    @(posedge clk); #1; err_clr = 1'b1;
    @(posedge clk); #1; err_clr = 1'b0;
  endtask

  task automatic chk_err(input logic exp, input string req);
    @(negedge clk);
    check(err == exp, req, {63'd0, err}, {63'd0, exp});
  endtask

  // Driver: queue the expected response, then present the request.
  task automatic lookup(input logic [63:0] a, input logic h,
                        input logic [7:0] p, input logic [3:0] w,
                        input string req);
    exp_q.push_back({h, p, w});
    tag_q.push_back(req);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b1, "R10 one-cycle latency", {63'd0, rsp_valid}, 64'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(err == 1'b0, "R1 err after reset", {63'd0, err}, 64'd0);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    check(req_ready == 1'b1, "R1 req_ready after reset", {63'd0, req_ready}, 64'd1);
    lookup(64'h0, 1'b0, 8'h00, 4'd0, "R1 empty table miss");

    // R3 full split, 4 GB window, wr_pe ignored
    wr(4'd0, 64'h40_0000_0000, mk(32), 3'd0, 1'b1, 8'h33, 1'b0);
    chk_err(1'b0, "R3 legal write");
    lookup(64'h40_0500_0000, 1'b1, 8'h05, 4'd0, "R3 segment 5");
    lookup(64'h40_FF00_0010, 1'b1, 8'hFF, 4'd0, "R3 top segment");

    // R4 single PE, 32 MB window
    wr(4'd3, 64'h80_0000_0000, mk(25), 3'd1, 1'b1, 8'h42, 1'b0);
    chk_err(1'b0, "R4 legal write");
    lookup(64'h80_01FF_FFFF, 1'b1, 8'h42, 4'd3, "R4 single PE");
    lookup(64'h80_0200_0000, 1'b0, 8'h00, 4'd0, "R7 just past window");

    // R8 single window of 16 MB rejected
    wr(4'd4, 64'h90_0000_0000, mk(24), 3'd1, 1'b1, 8'h11, 1'b0);
    chk_err(1'b1, "R8 small single window");
    lookup(64'h90_0000_0000, 1'b0, 8'h00, 4'd0, "R8 rejected entry stays off");
    clear_err();
    chk_err(1'b0, "R9 clear");

    // R8 misaligned rewrite of live entry 0 leaves it intact
    wr(4'd0, 64'h40_0000_1000, mk(32), 3'd0, 1'b1, 8'h00, 1'b0);
    chk_err(1'b1, "R8 misaligned base");
    lookup(64'h40_0500_0000, 1'b1, 8'h05, 4'd0, "R8 old entry survives");
    // R9 sticky across a good write
    wr(4'd9, 64'hD0_0000_0000, mk(30), 3'd0, 1'b1, 8'h00, 1'b0);
    chk_err(1'b1, "R9 sticky after good write");
    lookup(64'hD0_0100_0000, 1'b1, 8'h04, 4'd9, "R3 entry 9 segment 4");
    clear_err();

    // R8 non-contiguous mask, tiny split window, illegal mode
    wr(4'd5, 64'h0, 64'hFFFF_0000_FFFF_0000, 3'd0, 1'b1, 8'h00, 1'b0);
    chk_err(1'b1, "R8 non-contiguous mask");
    clear_err();
    wr(4'd5, 64'hE0_0000_0000, mk(7), 3'd0, 1'b1, 8'h00, 1'b0);
    chk_err(1'b1, "R8 split window below segment count");
    clear_err();
    wr(4'd5, 64'hE0_0000_0000, mk(30), 3'd5, 1'b1, 8'h00, 1'b0);
    chk_err(1'b1, "R8 illegal mode");
    lookup(64'hE0_0000_0000, 1'b0, 8'h00, 4'd0, "R8 entry 5 still off");
    // R9 rejection wins over same-cycle clear
    wr(4'd5, 64'hE0_0000_0000, mk(30), 3'd6, 1'b1, 8'h00, 1'b1);
    chk_err(1'b1, "R9 set beats clear");
    clear_err();

    // R5 extended split modes
    wr(4'd6, 64'hA0_0000_0000, mk(20), 3'd3, 1'b1, 8'h40, 1'b0);
    chk_err(1'b0, "R5 64-seg legal");
    lookup(64'hA0_0002_4000, 1'b1, 8'h49, 4'd6, "R5 64 segments base 0x40");
    wr(4'd7, 64'hB0_0000_0000, mk(12), 3'd3, 1'b1, 8'h50, 1'b0);
    chk_err(1'b1, "R8 base PE not multiple of 64");
    clear_err();
    wr(4'd7, 64'hB0_0000_0000, mk(12), 3'd2, 1'b1, 8'h18, 1'b0);
    chk_err(1'b0, "R5 8-seg legal");
    lookup(64'hB0_0000_0E00, 1'b1, 8'h1F, 4'd7, "R5 8 segments");
    wr(4'd8, 64'hC0_0000_0000, mk(16), 3'd4, 1'b1, 8'h80, 1'b0);
    lookup(64'hC0_0000_FE00, 1'b1, 8'hFF, 4'd8, "R5 128 segments");

    // R6 priority, R2 disable
    wr(4'd1, 64'h40_0000_0000, mk(25), 3'd1, 1'b1, 8'h77, 1'b0);
    lookup(64'h40_0000_0100, 1'b1, 8'h00, 4'd0, "R6 lower index wins");
    wr(4'd0, 64'h0, 64'h0, 3'd0, 1'b0, 8'h00, 1'b0);
    chk_err(1'b0, "R2 disable write accepted");
    lookup(64'h40_0000_0100, 1'b1, 8'h77, 4'd1, "R6 next window after disable");
    lookup(64'h40_0500_0000, 1'b0, 8'h00, 4'd0, "R2 disabled entry no hit");

    // R10 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    lookup(64'h80_0000_0000, 1'b1, 8'h42, 4'd3, "R10 held response");
    check(req_ready == 1'b0, "R10 req_ready low while held", {63'd0, req_ready}, 64'd0);
    repeat (3) @(negedge clk);
    check(rsp_valid && rsp_pe == 8'h42 && rsp_win == 4'd3, "R10 response stable",
          {51'd0, rsp_valid, rsp_pe, rsp_win}, {51'd0, 1'b1, 8'h42, 4'd3});
    @(posedge clk); #1 rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(rsp_valid == 1'b0, "R10 drained", {63'd0, rsp_valid}, 64'd0);
    check(exp_q.size() == 0, "R10 all responses seen", 64'(exp_q.size()), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule